// File: doc/BRIEF.md
# Transfer Error Halt and Resume Controller

This block sits beside the transfer engine of a serial bus controller. It watches eight error and event lines from that engine, each already detected elsewhere, and decides whether the controller must stop. A cause counts only in the mode or configuration it belongs to. A NACK on the broadcast address header counts only when the include-broadcast-address enable is set. The command-phase NACK and the transmit underflow and receive overflow flags count only while a double-data-rate transfer is in progress. The parity, CRC and frame-mismatch flags count only on read transfers. A completed software abort counts in every mode.

When a qualified cause is seen, the block enters a halted state. It pulses a valid strobe together with an error code for the response queue and drops its dispatch enable, so no new command starts. Only software can release the halt, by writing a resume bit. The block registers that write as a one-cycle request that clears itself. While halted, all further error inputs are ignored. When several causes arrive in the same cycle, a fixed priority picks one code.

Top module: `xfer_halt_ctrl`

## Requirements
- R1: After reset, `halted` is 0, `dispatch_en` is 1, `err_valid` is 0 and `err_code` is 0.
- R2: `abort_done` halts the block in every mode and reports code 1.
- R3: `bcast_nack` halts the block with code 2 only when `bcast_hdr_en` is 1. Otherwise it has no effect.
- R4: `ddr_cmd_nack` halts the block with code 3 only when `ddr_mode` is 1. Otherwise it has no effect.
- R5: `tx_underflow` (code 4) and `rx_overflow` (code 5) halt the block only when `ddr_mode` is 1. Otherwise they have no effect.
- R6: `parity_err` (code 6), `crc_err` (code 7) and `frame_err` (code 8) halt the block only when `rd_xfer` is 1. Otherwise they have no effect.
- R7: A qualified cause present before a rising edge sets `halted`, raises `err_valid` and loads `err_code` right after that edge. `err_valid` lasts exactly one cycle. `dispatch_en` is 0 whenever `halted` is 1.
- R8: When several qualified causes coincide, the reported code is the lowest of their codes: abort first, then broadcast NACK, command NACK, underflow, overflow, parity, CRC and frame.
- R9: While `halted` is 1, every error input is ignored. No new `err_valid` pulse occurs and `err_code` holds its value.
- R10: A one-cycle `resume_wr` pulse while halted clears `halted` and restores `dispatch_en` after the second rising edge following the pulse. The request clears itself, and a `resume_wr` pulse while not halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bcast_hdr_en | input | 1 | Include-broadcast-address configuration bit |
| ddr_mode | input | 1 | Double-data-rate transfer in progress |
| rd_xfer | input | 1 | Current transfer is a read |
| abort_done | input | 1 | Software abort has completed |
| bcast_nack | input | 1 | NACK on broadcast address header |
| ddr_cmd_nack | input | 1 | NACK on command/target-address phase |
| tx_underflow | input | 1 | Transmit data underflow |
| rx_overflow | input | 1 | Receive data overflow |
| parity_err | input | 1 | Read word parity error |
| crc_err | input | 1 | Read CRC byte error |
| frame_err | input | 1 | Read frame mismatch |
| resume_wr | input | 1 | Software write of 1 to resume bit |
| halted | output | 1 | Controller is halted |
| dispatch_en | output | 1 | New commands may be dispatched |
| err_valid | output | 1 | One-cycle strobe for the response queue |
| err_code | output | 4 | Error status code of the latest halt |

## Verification
A cause is due one register stage later. Cause inputs are driven just after an edge, and `halted`, `err_valid` and `err_code` are checked just after the next edge. `err_valid` is checked low one edge after that. Resume takes two register stages: `halted` is checked still high one edge after the pulse and low after the second edge. All checks sample a time unit after the edge, so they never race the registers. The sweep covers every pattern of the eight causes under every combination of the three qualifiers, and each pattern's expected code is worked out in the bench from the priority order.

// File: rtl/xfer_halt_pkg.sv
// Package: shared widths, cause indices and error codes of the halt controller.
// Assumes cause index order equals priority order (index 0 wins).
package xfer_halt_pkg;
    localparam int NUM_CAUSES = 8;
    localparam int CODE_W     = 4;

    // Cause vector positions, highest priority first
    localparam int C_ABORT   = 0;
    localparam int C_BNACK   = 1;
    localparam int C_CNACK   = 2;
    localparam int C_UNDER   = 3;
    localparam int C_OVER    = 4;
    localparam int C_PARITY  = 5;
    localparam int C_CRC     = 6;
    localparam int C_FRAME   = 7;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;
    typedef logic [CODE_W-1:0]     err_code_t;
endpackage

// File: rtl/xfer_halt_qualify.sv
// Module: gates each raw error input with the mode or configuration it
// belongs to and packs the result into a priority-ordered cause vector.
// Assumes raw inputs are already synchronous single-cycle or level flags.
module xfer_halt_qualify
    import xfer_halt_pkg::*;
(
    input  logic       bcast_hdr_en,
    input  logic       ddr_mode,
    input  logic       rd_xfer,
    input  logic       abort_done,
    input  logic       bcast_nack,
    input  logic       ddr_cmd_nack,
    input  logic       tx_underflow,
    input  logic       rx_overflow,
    input  logic       parity_err,
    input  logic       crc_err,
    input  logic       frame_err,
    output cause_vec_t causes
);
    // Purpose: apply per-cause qualification
    always_comb begin
        causes           = '0;
        causes[C_ABORT]  = abort_done;
        causes[C_BNACK]  = bcast_nack   & bcast_hdr_en;
        causes[C_CNACK]  = ddr_cmd_nack & ddr_mode;
        causes[C_UNDER]  = tx_underflow & ddr_mode;
        causes[C_OVER]   = rx_overflow  & ddr_mode;
        causes[C_PARITY] = parity_err   & rd_xfer;
        causes[C_CRC]    = crc_err      & rd_xfer;
        causes[C_FRAME]  = frame_err    & rd_xfer;
    end
endmodule

// File: rtl/xfer_halt_prio.sv
// Module: fixed-priority encoder; lowest set index wins, code = index + 1,
// code 0 means no cause. Assumes CODE_W can hold N.
module xfer_halt_prio #(
    parameter int N      = 8,
    parameter int CODE_W = 4
) (
    input  logic [N-1:0]      req,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    // Purpose: scan from lowest to highest priority so the winner is written last
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = CODE_W'(i + 1);
        end
    end

    // Purpose: flag any active request
    assign any = |req;
endmodule

// File: rtl/xfer_halt_state.sv
// Module: halt state register, one-cycle response strobe, held error code
// and self-clearing resume request. Assumes resume_wr is a write pulse.
module xfer_halt_state #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_any,
    input  logic [CODE_W-1:0] cause_code,
    input  logic              resume_wr,
    output logic              halted,
    output logic              err_valid,
    output logic [CODE_W-1:0] err_code
);
    logic resume_q;
    logic halt_set;

    // Purpose: a cause is accepted only while running
    assign halt_set = cause_any & ~halted;

    // Purpose: capture a resume write as a one-cycle request, only while halted
    always_ff @(posedge clk) begin
        if (!rst_n) resume_q <= 1'b0;
        else        resume_q <= resume_wr & halted & ~resume_q;
    end

    // Purpose: enter halt on an accepted cause, leave it on a resume request
    always_ff @(posedge clk) begin
        if (!rst_n)                halted <= 1'b0;
        else if (halt_set)         halted <= 1'b1;
        else if (halted && resume_q) halted <= 1'b0;
    end

    // Purpose: load the code and pulse the strobe for the response queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= '0;
        end else begin
            err_valid <= halt_set;
            if (halt_set) err_code <= cause_code;
        end
    end
endmodule

// File: rtl/xfer_halt_ctrl.sv
// Module: top of the transfer error halt and resume controller. Qualifies
// the causes, picks one by priority, and holds the halt until resume.
// Assumes all inputs are synchronous to clk.
module xfer_halt_ctrl
    import xfer_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcast_hdr_en,
    input  logic              ddr_mode,
    input  logic              rd_xfer,
    input  logic              abort_done,
    input  logic              bcast_nack,
    input  logic              ddr_cmd_nack,
    input  logic              tx_underflow,
    input  logic              rx_overflow,
    input  logic              parity_err,
    input  logic              crc_err,
    input  logic              frame_err,
    input  logic              resume_wr,
    output logic              halted,
    output logic              dispatch_en,
    output logic              err_valid,
    output logic [CODE_W-1:0] err_code
);
    cause_vec_t causes;
    logic       any_cause;
    err_code_t  win_code;

    xfer_halt_qualify u_qual (
        .bcast_hdr_en (bcast_hdr_en),
        .ddr_mode     (ddr_mode),
        .rd_xfer      (rd_xfer),
        .abort_done   (abort_done),
        .bcast_nack   (bcast_nack),
        .ddr_cmd_nack (ddr_cmd_nack),
        .tx_underflow (tx_underflow),
        .rx_overflow  (rx_overflow),
        .parity_err   (parity_err),
        .crc_err      (crc_err),
        .frame_err    (frame_err),
        .causes       (causes)
    );

    xfer_halt_prio #(.N(NUM_CAUSES), .CODE_W(CODE_W)) u_prio (
        .req  (causes),
        .any  (any_cause),
        .code (win_code)
    );

    xfer_halt_state #(.CODE_W(CODE_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_any  (any_cause),
        .cause_code (win_code),
        .resume_wr  (resume_wr),
        .halted     (halted),
        .err_valid  (err_valid),
        .err_code   (err_code)
    );

    // Purpose: block dispatch for as long as the halt lasts
    assign dispatch_en = ~halted;
endmodule

// File: rtl/xfer_halt_ctrl_chk.sv
// Checker: temporal properties of the halt controller, bound to the top.
module xfer_halt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       abort_done,
    input logic       resume_wr,
    input logic       halted,
    input logic       dispatch_en,
    input logic       err_valid,
    input logic [3:0] err_code
);
    AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && abort_done) |=> (halted && err_valid && err_code == 4'd1)); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid); // R7

    AST_NO_DISPATCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !dispatch_en); // R7

    AST_QUIET_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !err_valid) |=> (!err_valid && $stable(err_code))); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume_wr && !$past(resume_wr)) |=> halted); // R10

    AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && resume_wr && !$past(resume_wr)) |=> ##1 (!halted && dispatch_en)); // R10
endmodule

bind xfer_halt_ctrl xfer_halt_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_done  (abort_done),
    .resume_wr   (resume_wr),
    .halted      (halted),
    .dispatch_en (dispatch_en),
    .err_valid   (err_valid),
    .err_code    (err_code)
);

// File: tb/xfer_halt_ctrl_tb_top.sv
// Bench: sweeps every cause pattern under every qualifier combination.
module xfer_halt_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bcast_hdr_en = 0, ddr_mode = 0, rd_xfer = 0;
    logic [7:0] raw = '0;
    logic resume_wr = 0;
    logic halted, dispatch_en, err_valid;
    logic [3:0] err_code;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xfer_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bcast_hdr_en(bcast_hdr_en), .ddr_mode(ddr_mode), .rd_xfer(rd_xfer),
        .abort_done(raw[0]), .bcast_nack(raw[1]), .ddr_cmd_nack(raw[2]),
        .tx_underflow(raw[3]), .rx_overflow(raw[4]), .parity_err(raw[5]),
        .crc_err(raw[6]), .frame_err(raw[7]), .resume_wr(resume_wr),
        .halted(halted), .dispatch_en(dispatch_en),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int exp_code;
        logic [7:0] q;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 halted", halted, 0);
        chk("R1 dispatch_en", dispatch_en, 1);
        chk("R1 err_valid", err_valid, 0);
        chk("R1 err_code", err_code, 0);
        // R10 resume while running has no effect
        resume_wr = 1; tick(); resume_wr = 0; tick();
        chk("R10 idle resume halted", halted, 0);
        chk("R10 idle resume dispatch", dispatch_en, 1);
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int pat = 0; pat < 256; pat++) begin
                bcast_hdr_en = cfg[0]; ddr_mode = cfg[1]; rd_xfer = cfg[2];
                // qualification R2..R6
                q = pat[7:0];
                q[1] = q[1] & cfg[0];
                q[2] = q[2] & cfg[1];
                q[3] = q[3] & cfg[1];
                q[4] = q[4] & cfg[1];
                q[5] = q[5] & cfg[2];
                q[6] = q[6] & cfg[2];
                q[7] = q[7] & cfg[2];
                exp_code = 0;
                for (int i = 7; i >= 0; i--) if (q[i]) exp_code = i + 1;  // R8
                raw = pat[7:0];
                tick();
                raw = '0;
                if (exp_code == 0) begin
                    // R3 R4 R5 R6 unqualified causes have no effect
                    chk("R3/R4/R5/R6 no halt", halted, 0);
                    chk("R3/R4/R5/R6 no strobe", err_valid, 0);
                    chk("R7 dispatch kept", dispatch_en, 1);
                end else begin
                    chk("R7 halted", halted, 1);
                    chk("R7 strobe", err_valid, 1);
                    chk("R7 dispatch off", dispatch_en, 0);
                    chk("R2/R8 code", err_code, exp_code);
                    tick();
                    chk("R7 strobe one cycle", err_valid, 0);
                    // R9 causes ignored while halted
                    raw = 8'hFF; bcast_hdr_en = 1; ddr_mode = 1; rd_xfer = 1;
                    tick();
                    raw = '0;
                    chk("R9 no strobe", err_valid, 0);
                    chk("R9 code held", err_code, exp_code);
                    chk("R9 still halted", halted, 1);
                    // R10 resume timing
                    resume_wr = 1; tick(); resume_wr = 0;
                    chk("R10 halted after 1 edge", halted, 1);
                    tick();
                    chk("R10 released", halted, 0);
                    chk("R10 dispatch back", dispatch_en, 1);
                    chk("R10 no strobe", err_valid, 0);
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule